// File: doc/BRIEF.md
# Prioritised Interrupt Arbiter with Claim/Complete Handshake

This block gathers a parameterised set of external interrupt lines, numbered 1 to `NUM_SRC`, and steers them to `NUM_CTX` processor contexts. Every source passes through a gateway, which works as level-high or rising-edge, chosen per source by the `EDGE_MASK` parameter. Every source has a programmable priority. Every context has an enable bit per source and a priority threshold. A context's request line goes high whenever some pending source is enabled for it and has a priority strictly above its threshold.

Software services an interrupt in two steps. It reads the context's claim register, which returns the winning source ID and takes that source out of the pending set. When the handler finishes, software writes the same ID back to the register. Until that write arrives, the gateway forwards no new request from the source. An edge-triggered source keeps a rising edge that arrives in the meantime and presents it again after completion.

Every register sits behind a single-cycle 32-bit access port. The address map is sparse and fixed: a priority window at 0x0, enable vectors at 0x2000, and per-context control blocks at 0x200000.

Each gateway is a four-state machine:
- IDLE: no request is held.
- PEND: a request is waiting to be claimed.
- BUSY: the request has been claimed and completion is outstanding.
- BUSY_HELD: BUSY, plus a rising edge seen while in service. This state is reachable only for edge sources.

The transitions are:
- IDLE to PEND on a trigger. The trigger is a high level for level sources and a 0-to-1 change for edge sources.
- PEND to BUSY on a claim. This goes to BUSY_HELD instead if an edge arrives in the same cycle.
- BUSY to IDLE on completion. This goes to PEND instead if an edge arrives in the same cycle.
- BUSY to BUSY_HELD on an edge.
- BUSY_HELD to PEND on completion.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Source ID 0 is absent. Its priority word at 0x0 reads 0 even after a write, bit 0 of every context's first enable word reads 0, and a claim read returns 0 when no eligible source is pending.
- R2: The priority of source n is at byte address 4*n and holds 3 bits, so bits 31:3 read 0. Writes to IDs above `NUM_SRC` have no effect, and those words read 0.
- R3: The enable word w of context c is at 0x2000 + 0x80*c + 4*w, and source n is bit (n mod 32) of word (n div 32). Bits of sources that do not exist read 0. A write to one word changes no other word and no other context.
- R4: The threshold of context c is at 0x200000 + 0x1000*c (3 bits, upper bits read 0), and its claim/complete register is at offset +4 from that address.
- R5: A context's request is high exactly when some pending source enabled for it has a priority strictly greater than its threshold. Priority 0 never interrupts, and threshold 7 blocks everything.
- R6: A claim read returns the enabled, pending, above-threshold source with the highest priority, with ties going to the lowest ID. The same read clears that source's pending state.
- R7: After a claim, a level source raises no new request until its ID is written to the claim register. After that write, a source that is still high becomes pending again.
- R8: An edge source that sees a 0-to-1 change while claimed keeps that event and becomes pending once completed. Several edges while pending merge into a single request.
- R9: A completion write is ignored if the ID is not enabled for the context written, or if the source is not currently claimed.
- R10: Reads of unmapped or misaligned addresses return 0.
- R11: The request output is registered. A source rising in one cycle moves its gateway to PEND at the next edge, and the request output rises at the edge after that.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | NUM_SRC | Interrupt lines; bit k is source k+1 |
| acc_req_i | input | 1 | Access strobe, one cycle per access |
| acc_we_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | ADDR_W | Byte address |
| acc_wdata_i | input | 32 | Write data |
| acc_rdata_o | output | 32 | Read data, valid from the edge that ends the read cycle |
| irq_o | output | NUM_CTX | Per-context interrupt request |

## Verification
The embedded properties check the following on every cycle:
- A claim reaches at most one gateway, and only a gateway that is in PEND.
- A claimed gateway never shows pending again without a completion.
- An edge seen while in service is never dropped.
- A maximum threshold forces the request low one cycle later.
- Unmapped reads and empty claims return zero.

The bench scenarios cover the rest: the exact priority and tie order of a claim sequence, the full priority-by-threshold gating sweep, the bit placement in the enable words, which completion writes are rejected, and the two-edge latency of a request.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam logic [31:0] EN_BASE    = 32'h0000_2000;
    localparam logic [31:0] CTX_BASE   = 32'h0020_0000;
    localparam int unsigned EN_SHIFT   = 7;   // 0x80 bytes per context
    localparam int unsigned CTX_SHIFT  = 12;  // 0x1000 bytes per context
    localparam logic [11:0] OFF_THR    = 12'h000;
    localparam logic [11:0] OFF_CLAIM  = 12'h004;

    typedef enum logic [1:0] {
        GW_IDLE,
        GW_PEND,
        GW_BUSY,
        GW_BUSY_HELD
    } gw_state_e;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_PRIO,
        RG_EN,
        RG_THR,
        RG_CLAIM
    } region_e;

endpackage

// File: rtl/pic_gateway.sv
module pic_gateway
    import pic_pkg::*;
#(
    parameter bit EDGE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic claim_i,
    input  logic complete_i,
    output logic pending_o
);

    gw_state_e state_q, state_d;
    logic      trig;

    generate
        if (EDGE) begin : g_edge
            logic src_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) src_q <= 1'b0;
                else        src_q <= src_i;
            end
            assign trig = src_i & ~src_q;
        end else begin : g_level
            assign trig = src_i;
        end
    endgenerate

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GW_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GW_IDLE: begin
                if (trig) state_d = GW_PEND;
            end
            GW_PEND: begin
                if (claim_i) state_d = (EDGE && trig) ? GW_BUSY_HELD : GW_BUSY;
            end
            GW_BUSY: begin
                if (complete_i)        state_d = (EDGE && trig) ? GW_PEND : GW_IDLE;
                else if (EDGE && trig) state_d = GW_BUSY_HELD;
            end
            GW_BUSY_HELD: begin
                if (complete_i) state_d = GW_PEND;
            end
            default: state_d = GW_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pending_o = (state_q == GW_PEND);
    end

    assert_claim_needs_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        claim_i |-> (state_q == GW_PEND));

    assert_busy_no_rereq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GW_BUSY && !complete_i) |=> !pending_o);

    generate
        if (EDGE) begin : g_edge_chk
            assert_edge_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
                (state_q == GW_BUSY && trig) |=> (state_q != GW_IDLE));
        end
    endgenerate

endmodule

// File: rtl/pic_select.sv
module pic_select #(
    parameter int unsigned NUM_SRC = 40,
    parameter int unsigned PRIO_W  = 3,
    parameter int unsigned ID_W    = 6
) (
    input  logic [NUM_SRC:0]             pend_i,
    input  logic [NUM_SRC:0]             en_i,
    input  logic [NUM_SRC:0][PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]            thr_i,
    output logic [ID_W-1:0]              best_id_o
);

    logic [PRIO_W-1:0] best_p;

    // Ascending scan with a strict compare: the lowest ID keeps a tie,
    // and seeding with the threshold makes the gating strict.
    always_comb begin
        best_p    = thr_i;
        best_id_o = '0;
        for (int i = 0; i <= int'(NUM_SRC); i++) begin
            if (pend_i[i] && en_i[i] && (prio_i[i] > best_p)) begin
                best_p    = prio_i[i];
                best_id_o = ID_W'(i);
            end
        end
    end

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import pic_pkg::*;
#(
    parameter int unsigned       NUM_SRC   = 40,
    parameter int unsigned       NUM_CTX   = 2,
    parameter int unsigned       PRIO_W    = 3,
    parameter int unsigned       ADDR_W    = 24,
    parameter logic [NUM_SRC-1:0] EDGE_MASK = 40'hFF_0000_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               acc_req_i,
    input  logic               acc_we_i,
    input  logic [ADDR_W-1:0]  acc_addr_i,
    input  logic [31:0]        acc_wdata_i,
    output logic [31:0]        acc_rdata_o,
    output logic [NUM_CTX-1:0] irq_o
);

    localparam int unsigned ID_W     = $clog2(NUM_SRC + 1);
    localparam int unsigned CTX_W    = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;
    localparam int unsigned EN_WORDS = NUM_SRC / 32 + 1;

    // architectural state
    logic [NUM_SRC:0][PRIO_W-1:0]  prio_q;
    logic [NUM_CTX-1:0][NUM_SRC:0] en_q;
    logic [NUM_CTX-1:0][PRIO_W-1:0] thr_q;
    logic [31:0]                   rdata_q;
    logic [NUM_CTX-1:0]            irq_q;

    // gateway and arbitration nets
    logic [NUM_SRC:0]              pend;
    logic [NUM_SRC:1]              claim_vec;
    logic [NUM_SRC:1]              complete_vec;
    logic [NUM_CTX-1:0][ID_W-1:0]  best_id;

    // decode
    region_e          region;
    logic [ID_W-1:0]  sel_id;
    logic [CTX_W-1:0] sel_ctx;
    logic [4:0]       sel_word;
    logic [31:0]      a32;
    logic [31:0]      off;
    logic [31:0]      rd_val;

    assign pend[0] = 1'b0;

    generate
        for (genvar g = 1; g <= int'(NUM_SRC); g++) begin : g_gw
            pic_gateway #(.EDGE(EDGE_MASK[g-1])) u_gw (
                .clk        (clk),
                .rst_n      (rst_n),
                .src_i      (src_i[g-1]),
                .claim_i    (claim_vec[g]),
                .complete_i (complete_vec[g]),
                .pending_o  (pend[g])
            );
        end

        for (genvar c = 0; c < int'(NUM_CTX); c++) begin : g_ctx
            pic_select #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .ID_W(ID_W)) u_sel (
                .pend_i    (pend),
                .en_i      (en_q[c]),
                .prio_i    (prio_q),
                .thr_i     (thr_q[c]),
                .best_id_o (best_id[c])
            );

            assert_thr_max_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (thr_q[c] == '1) |=> !irq_o[c]);
        end
    endgenerate

    // address decode
    always_comb begin
        region   = RG_NONE;
        sel_id   = '0;
        sel_ctx  = '0;
        sel_word = '0;
        off      = '0;
        a32      = 32'(acc_addr_i);
        if (a32[1:0] == 2'b00) begin
            if (a32 < EN_BASE) begin
                if ((a32 >> 2) <= NUM_SRC) begin
                    region = RG_PRIO;
                    sel_id = ID_W'(a32 >> 2);
                end
            end else if (a32 < CTX_BASE) begin
                off = a32 - EN_BASE;
                if (((off >> EN_SHIFT) < NUM_CTX) && (32'(off[6:2]) < EN_WORDS)) begin
                    region   = RG_EN;
                    sel_ctx  = CTX_W'(off >> EN_SHIFT);
                    sel_word = off[6:2];
                end
            end else begin
                off = a32 - CTX_BASE;
                if ((off >> CTX_SHIFT) < NUM_CTX) begin
                    sel_ctx = CTX_W'(off >> CTX_SHIFT);
                    if (off[11:0] == OFF_THR)        region = RG_THR;
                    else if (off[11:0] == OFF_CLAIM) region = RG_CLAIM;
                end
            end
        end
    end

    // read mux
    always_comb begin
        rd_val = '0;
        unique case (region)
            RG_PRIO:  rd_val = 32'(prio_q[sel_id]);
            RG_EN: begin
                for (int b = 0; b < 32; b++) begin
                    if ((32 * int'(sel_word) + b) >= 1 && (32 * int'(sel_word) + b) <= int'(NUM_SRC))
                        rd_val[b] = en_q[sel_ctx][32 * int'(sel_word) + b];
                end
            end
            RG_THR:   rd_val = 32'(thr_q[sel_ctx]);
            RG_CLAIM: rd_val = 32'(best_id[sel_ctx]);
            default:  rd_val = '0;
        endcase
    end

    // claim and completion strobes to the gateways
    always_comb begin
        claim_vec    = '0;
        complete_vec = '0;
        if (acc_req_i && region == RG_CLAIM) begin
            for (int i = 1; i <= int'(NUM_SRC); i++) begin
                if (!acc_we_i && best_id[sel_ctx] == ID_W'(i))
                    claim_vec[i] = 1'b1;
                if (acc_we_i && acc_wdata_i == 32'(i) && en_q[sel_ctx][i])
                    complete_vec[i] = 1'b1;
            end
        end
    end

    // register writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prio_q <= '0;
            en_q   <= '0;
            thr_q  <= '0;
        end else if (acc_req_i && acc_we_i) begin
            case (region)
                RG_PRIO: begin
                    if (sel_id != '0) prio_q[sel_id] <= acc_wdata_i[PRIO_W-1:0];
                end
                RG_EN: begin
                    for (int b = 0; b < 32; b++) begin
                        if ((32 * int'(sel_word) + b) >= 1 && (32 * int'(sel_word) + b) <= int'(NUM_SRC))
                            en_q[sel_ctx][32 * int'(sel_word) + b] <= acc_wdata_i[b];
                    end
                end
                RG_THR:  thr_q[sel_ctx] <= acc_wdata_i[PRIO_W-1:0];
                default: ;
            endcase
        end
    end

    // read data and request outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
            irq_q   <= '0;
        end else begin
            if (acc_req_i && !acc_we_i) rdata_q <= rd_val;
            for (int c = 0; c < int'(NUM_CTX); c++)
                irq_q[c] <= (best_id[c] != '0);
        end
    end

    assign acc_rdata_o = rdata_q;
    assign irq_o       = irq_q;

    assert_claim_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(claim_vec));

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req_i && !acc_we_i && region == RG_NONE) |=> (acc_rdata_o == 32'h0));

    assert_empty_claim_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req_i && !acc_we_i && region == RG_CLAIM && claim_vec == '0) |=> (acc_rdata_o == 32'h0));

endmodule

// File: tb/prio_irq_ctrl_tb.sv
module prio_irq_ctrl_tb;

    localparam int NSRC = 40;
    localparam int NCTX = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] src = '0;
    logic            req = 1'b0;
    logic            we = 1'b0;
    logic [23:0]     addr = '0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic [NCTX-1:0] irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    prio_irq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .src_i(src),
        .acc_req_i(req), .acc_we_i(we), .acc_addr_i(addr),
        .acc_wdata_i(wdata), .acc_rdata_o(rdata), .irq_o(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        req = 1'b1; we = 1'b1; addr = a[23:0]; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        req = 1'b1; we = 1'b0; addr = a[23:0];
        @(negedge clk);
        req = 1'b0;
        d = rdata;
    endtask

    // enable word w of context c, threshold and claim of context c
    function automatic logic [31:0] en_a(input int c, input int w);
        return 32'h2000 + 32'(c) * 32'h80 + 32'(w) * 4;
    endfunction
    function automatic logic [31:0] thr_a(input int c);
        return 32'h20_0000 + 32'(c) * 32'h1000;
    endfunction
    function automatic logic [31:0] clm_a(input int c);
        return 32'h20_0000 + 32'(c) * 32'h1000 + 4;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // reset state
        check("R11 reset irq", 32'(irq), 0);
        rd(clm_a(0), d); check("R1 empty claim", d, 0);
        wr(32'h0, 32'h7);
        rd(32'h0, d);    check("R1 id0 priority", d, 0);

        // R2 priority width and range
        wr(32'h14, 32'hFFFF_FFFD);
        rd(32'h14, d);   check("R2 prio masked", d, 32'h5);
        wr(32'(4 * (NSRC + 1)), 32'h3);
        rd(32'(4 * (NSRC + 1)), d); check("R2 beyond range", d, 0);
        wr(32'h14, 0);

        // R3 enable layout and isolation
        wr(en_a(0, 0), 32'hFFFF_FFFF);
        rd(en_a(0, 0), d); check("R3 word0 bit0 zero (R1)", d, 32'hFFFF_FFFE);
        wr(en_a(0, 0), 32'h12);
        wr(en_a(0, 1), 32'hFFFF_FFFF);
        rd(en_a(0, 1), d); check("R3 word1 only real sources", d, 32'h1FF);
        rd(en_a(0, 0), d); check("R3 word0 untouched", d, 32'h12);
        rd(en_a(1, 0), d); check("R3 other context untouched", d, 0);
        wr(en_a(0, 0), 0);
        wr(en_a(0, 1), 0);

        // R4 threshold
        wr(thr_a(1), 32'hF);
        rd(thr_a(1), d); check("R4 threshold masked", d, 7);
        wr(thr_a(1), 0);

        // R10 unmapped
        rd(32'h1800, d);     check("R10 hole", d, 0);
        rd(32'h20_0008, d);  check("R10 ctx gap", d, 0);
        rd(32'h20_2000, d);  check("R10 missing ctx", d, 0);
        rd(32'h16, d);       check("R10 misaligned", d, 0);

        // R5 exhaustive priority x threshold on level source 3, ctx0 only
        wr(en_a(0, 0), 32'h8);
        src[2] = 1'b1;
        for (int p = 0; p < 8; p++) begin
            for (int t = 0; t < 8; t++) begin
                wr(32'h0C, 32'(p));
                wr(thr_a(0), 32'(t));
                tick(2);
                check($sformatf("R5 ctx0 p=%0d t=%0d", p, t), 32'(irq[0]), (p > t) ? 1 : 0);
                check("R5 ctx1 not enabled", 32'(irq[1]), 0);
            end
        end
        wr(thr_a(0), 0);

        // R6 priority order and tie break: 3->2, 5->6, 7->6
        wr(32'h0C, 2); wr(32'h14, 6); wr(32'h1C, 6);
        wr(en_a(0, 0), 32'hA8);
        @(negedge clk); src[4] = 1'b1; src[6] = 1'b1;
        tick(3);
        rd(clm_a(0), d); check("R6 first claim", d, 5);
        rd(clm_a(0), d); check("R6 tie lowest id", d, 7);
        rd(clm_a(0), d); check("R6 lower prio", d, 3);
        rd(clm_a(0), d); check("R6 all claimed", d, 0);
        tick(2);
        check("R6 irq cleared", 32'(irq[0]), 0);

        // R7 level no re-request until completion
        tick(3);
        rd(clm_a(0), d); check("R7 busy no request", d, 0);
        wr(clm_a(0), 5);
        tick(3);
        check("R7 irq after complete", 32'(irq[0]), 1);
        rd(clm_a(0), d); check("R7 re-pend", d, 5);
        src[4] = 1'b0;
        wr(clm_a(0), 5);
        tick(3);
        rd(clm_a(0), d); check("R7 low after complete", d, 0);

        // R9 completion on a context without the enable is ignored
        wr(clm_a(1), 3);
        tick(3);
        rd(clm_a(0), d); check("R9 foreign ctx ignored", d, 0);
        wr(clm_a(0), 3);
        tick(3);
        rd(clm_a(0), d); check("R9 valid complete", d, 3);
        src[2] = 1'b0; src[6] = 1'b0;
        wr(clm_a(0), 3); wr(clm_a(0), 7);
        tick(3);
        rd(clm_a(0), d); check("R9 idle after completes", d, 0);
        // not-claimed completion: source 3 pending, complete ignored, still claimable
        @(negedge clk); src[2] = 1'b1;
        tick(3);
        wr(clm_a(0), 3);
        tick(2);
        rd(clm_a(0), d); check("R9 unclaimed complete ignored", d, 3);
        src[2] = 1'b0;
        wr(clm_a(0), 3);
        wr(en_a(0, 0), 0);

        // R8 / R11 edge source 33 on ctx1
        wr(32'(4 * 33), 4);
        wr(en_a(1, 1), 32'h2);
        tick(2);
        @(negedge clk); src[32] = 1'b1;
        @(negedge clk); src[32] = 1'b0;
        check("R11 irq not yet", 32'(irq[1]), 0);
        @(negedge clk);
        check("R11 irq second edge", 32'(irq[1]), 1);
        rd(clm_a(1), d); check("R8 edge claim", d, 33);
        @(negedge clk); src[32] = 1'b1;
        @(negedge clk); src[32] = 1'b0;
        tick(2);
        rd(clm_a(1), d); check("R8 held while busy", d, 0);
        wr(clm_a(1), 33);
        tick(3);
        rd(clm_a(1), d); check("R8 held edge delivered", d, 33);
        wr(clm_a(1), 33);
        tick(3);
        rd(clm_a(1), d); check("R8 nothing more", d, 0);
        @(negedge clk); src[32] = 1'b1;
        @(negedge clk); src[32] = 1'b0;
        @(negedge clk); src[32] = 1'b1;
        @(negedge clk); src[32] = 1'b0;
        tick(2);
        rd(clm_a(1), d); check("R8 merged claim", d, 33);
        wr(clm_a(1), 33);
        tick(3);
        rd(clm_a(1), d); check("R8 merged once", d, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule